// File: doc/BRIEF.md
# Watchdog Result Serial Framer

This block sends the result of a limit-watchdog scan out over one serial data line. When the chip-select input falls, it takes a snapshot of four parallel words: the first-failure tag, the stored channel configuration, a sticky power-interrupt flag and the per-limit status bits. It loads them into one frame register. Each later falling edge of the serial clock moves the next bit onto the data-out line, so the receiver can sample on the rising edge. The frame holds the tag (4 bits), then the configuration (12 bits), then the power-interrupt bit, then the status field. Each field goes out most significant bit first. The status field is two bits per channel, so a 2-channel build sends 21 bits and an 8-channel build sends 33 bits.

The power-interrupt flag is set by a one-cycle power-fail pulse. It stays set until a dedicated clear input is pulsed, and reading a frame does not clear it. The serial clock and chip select are sampled in the system clock domain, and edges are found by comparing each with its value one cycle earlier. The controller has four named states:
- IDLE: waiting for chip select to fall. A fall goes to SHIFT and loads the frame.
- SHIFT: bits are presented on data-out. A rise of chip select goes back to IDLE, which is an abort. A serial clock fall on the last bit goes to DONE.
- DONE: lasts one cycle with frame-done high. It then goes to HOLD, or to IDLE if chip select is already high.
- HOLD: data-out is idle low until chip select rises, and then the controller returns to IDLE.

Top module: `wdf_top`

## Requirements
- R1: After reset, dout is 0, frame_done is 0 and the power-interrupt flag is clear, so the next frame carries P = 0.
- R2: On the clock cycle in which cs_n is sampled low after being high, the four input fields are captured. From the following cycle, dout shows the tag MSB (T3).
- R3: The frame holds tag[3:0], then cfg[11:0], then P, then status[2*NUM_CH-1:0], each field MSB first. Its length is 17 + 2*NUM_CH bits.
- R4: During a frame, dout advances by exactly one bit per sampled falling edge of sclk. At all other times it stays stable.
- R5: Changes on tag_in, cfg_in and stat_in after capture do not alter the frame being sent.
- R6: A pwr_fail pulse sets P, and P stays set across any number of frames until a p_clr pulse clears it.
- R7: When pwr_fail and p_clr are high in the same cycle, P ends up set.
- R8: If cs_n rises before the frame is complete, the transfer is dropped and dout goes to 0 in the next cycle. The next fall of cs_n restarts the frame at T3.
- R9: The sclk fall that ends the last status bit causes frame_done to be high for exactly one cycle. From then until cs_n rises, dout stays 0 and further sclk edges have no effect.
- R10: With NUM_CH = 2, tag 0010, P = 0 and status 1001, the frame reads 0010, then cfg[11:0], then 0, then 1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; its fall starts a frame |
| sclk | input | 1 | Serial clock; data advances on its fall |
| tag_in | input | 4 | First-failure tag from the watchdog core |
| cfg_in | input | 12 | Stored channel configuration |
| stat_in | input | 2*NUM_CH | Per-limit crossing status bits |
| pwr_fail | input | 1 | One-cycle power-fail event; sets the sticky flag |
| p_clr | input | 1 | Clears the sticky power-interrupt flag |
| dout | output | 1 | Serial data out, idle 0 |
| frame_done | output | 1 | One-cycle pulse after the last bit |

## Verification
Two functions can meet in one cycle: setting the sticky power flag and clearing it. The bench drives pwr_fail and p_clr high together for one cycle between frames. It then reads the next frame and expects the P bit to be 1, because set takes priority. It repeats the check after a clear-only pulse, which must give 0. A second collision puts a chip-select rise in the middle of a frame while bits are still shifting. That case is judged by dout going to 0 at once and by a clean restart from T3 on the next frame.

// File: rtl/wdf_pkg.sv
package wdf_pkg;
    localparam int TAG_W = 4;
    localparam int CFG_W = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DONE,
        ST_HOLD
    } wdf_state_t;
endpackage

// File: rtl/wdf_edge_det.sv
module wdf_edge_det #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RESET_VAL;
        else     prev_q <= sig_in;
    end

    assign rise = !prev_q && sig_in;
    assign fall = prev_q && !sig_in;
endmodule

// File: rtl/wdf_pwr_flag.sv
module wdf_pwr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);
    // set has priority over clear when both arrive together
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end
endmodule

// File: rtl/wdf_frame_sr.sv
module wdf_frame_sr #(
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] load_word,
    output logic             msb
);
    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)        sr_q <= '0;
        else if (load)  sr_q <= load_word;
        else if (shift) sr_q <= {sr_q[WIDTH-2:0], 1'b0};
    end

    assign msb = sr_q[WIDTH-1];
endmodule

// File: rtl/wdf_top.sv
module wdf_top
    import wdf_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int STAT_W  = 2 * NUM_CH,
    localparam int FRAME_W = TAG_W + CFG_W + 1 + STAT_W,
    localparam int IDX_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [CFG_W-1:0]  cfg_in,
    input  logic [STAT_W-1:0] stat_in,
    input  logic              pwr_fail,
    input  logic              p_clr,
    output logic              dout,
    output logic              frame_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    wdf_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             cs_rise, cs_fall, sclk_rise_unused, sclk_fall;
    logic             p_flag_q;
    logic             sr_msb;
    logic             load_en, shift_en;
    logic [FRAME_W-1:0] frame_word;

    wdf_edge_det #(.RESET_VAL(1'b1)) u_cs_edge (
        .clk(clk), .rst(rst), .sig_in(cs_n),
        .rise(cs_rise), .fall(cs_fall)
    );

    wdf_edge_det #(.RESET_VAL(1'b1)) u_sclk_edge (
        .clk(clk), .rst(rst), .sig_in(sclk),
        .rise(sclk_rise_unused), .fall(sclk_fall)
    );

    wdf_pwr_flag u_pflag (
        .clk(clk), .rst(rst), .set_evt(pwr_fail), .clr_evt(p_clr),
        .flag(p_flag_q)
    );

    assign frame_word = {tag_in, cfg_in, p_flag_q, stat_in};

    wdf_frame_sr #(.WIDTH(FRAME_W)) u_sr (
        .clk(clk), .rst(rst), .load(load_en), .shift(shift_en),
        .load_word(frame_word), .msb(sr_msb)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        load_en  = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) begin
                    state_d = ST_SHIFT;
                    load_en = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (cs_n) begin
                    state_d = ST_IDLE;
                end else if (sclk_fall) begin
                    shift_en = 1'b1;
                    if (idx_q == LAST_IDX) state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = cs_n ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and bit index
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_en)       idx_q <= '0;
            else if (shift_en) idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        dout       = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SHIFT: dout = sr_msb;
            ST_DONE:  frame_done = 1'b1;
            ST_HOLD:  ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/wdf_chk.sv
module wdf_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic pwr_fail,
    input logic p_clr,
    input logic p_flag,
    input logic dout,
    input logic frame_done
);
    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R8: chip select high for two samples means idle data-out
    p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !dout);

    // R4: no serial clock fall and no capture means data-out holds
    p_hold_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n) && !($past(sclk) && !sclk)) |=> $stable(dout));

    // R6: power-fail sets the flag
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> p_flag);

    // R6: clear alone clears the flag
    p_flag_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (p_clr && !pwr_fail) |=> !p_flag);

    // R6: flag only changes on an event
    p_flag_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (!p_clr && !pwr_fail) |=> $stable(p_flag));

    // R7: simultaneous set and clear leaves the flag set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (p_clr && pwr_fail) |=> p_flag);
endmodule

bind wdf_top wdf_chk u_wdf_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .pwr_fail(pwr_fail), .p_clr(p_clr), .p_flag(p_flag_q),
    .dout(dout), .frame_done(frame_done)
);

// File: tb/tb_wdf_top.sv
module tb_wdf_top;
    localparam int NUM_CH  = 2;
    localparam int STAT_W  = 2 * NUM_CH;
    localparam int FRAME_W = 4 + 12 + 1 + STAT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic [3:0]        tag_in  = '0;
    logic [11:0]       cfg_in  = '0;
    logic [STAT_W-1:0] stat_in = '0;
    logic pwr_fail = 1'b0;
    logic p_clr    = 1'b0;
    logic dout, frame_done;

    int total = 0;
    int bad   = 0;
    bit exp_p = 1'b0;

    always #5 clk = ~clk;

    wdf_top #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .tag_in(tag_in), .cfg_in(cfg_in), .stat_in(stat_in),
        .pwr_fail(pwr_fail), .p_clr(p_clr),
        .dout(dout), .frame_done(frame_done)
    );

    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [3:0] t, input logic [11:0] c,
        input logic p, input logic [STAT_W-1:0] s);
        return {t, c, p, s};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_flags(input logic pf, input logic pc);
        pwr_fail = pf; p_clr = pc;
        tick();
        pwr_fail = 1'b0; p_clr = 1'b0;
        tick();
    endtask

    // full frame; scramble inputs after capture (R5)
    task automatic run_frame(input logic [3:0] t, input logic [11:0] c,
                             input logic [STAT_W-1:0] s, input string req);
        logic [FRAME_W-1:0] exp_w, got;
        exp_w = build_frame(t, c, exp_p, s);
        tag_in = t; cfg_in = c; stat_in = s;
        cs_n = 1'b0;
        tick();
        tag_in = 4'($urandom); cfg_in = 12'($urandom); stat_in = STAT_W'($urandom);
        got = '0;
        for (int i = 0; i < FRAME_W; i++) begin
            got[FRAME_W-1-i] = dout;
            sclk = 1'b0;
            tick();
            if (i == FRAME_W - 1) begin
                check({req, " R9 done pulse"}, 64'(frame_done), 64'd1);
                check("R9 dout idle at done", 64'(dout), 64'd0);
            end
            sclk = 1'b1;
            tick();
        end
        check({req, " R3 frame"}, 64'(got), 64'(exp_w));
        check("R9 done one cycle", 64'(frame_done), 64'd0);
        for (int k = 0; k < 2; k++) begin
            sclk = 1'b0; tick(); sclk = 1'b1; tick();
            check("R9 extra sclk ignored", 64'({dout, frame_done}), 64'd0);
        end
        cs_n = 1'b1;
        tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 reset dout", 64'(dout), 64'd0);
        check("R1 reset done", 64'(frame_done), 64'd0);

        // R10 and R1: example frame, flag clear after reset
        run_frame(4'b0010, 12'hA5C, 4'b1001, "R10");

        // R2: first bit visible right after capture
        tag_in = 4'b1000; cfg_in = '0; stat_in = '0;
        cs_n = 1'b0; tick();
        check("R2 T3 on dout", 64'(dout), 64'd1);
        // R4: no sclk fall, bit holds
        tick(); tick();
        check("R4 hold without sclk", 64'(dout), 64'd1);
        sclk = 1'b0; tick();
        check("R4 advance on fall", 64'(dout), 64'd0);
        sclk = 1'b1; tick();
        // R8: abort mid-frame
        tag_in = 4'b1111;
        for (int i = 0; i < 2; i++) begin sclk = 1'b0; tick(); sclk = 1'b1; tick(); end
        cs_n = 1'b1; tick();
        check("R8 abort idle", 64'({dout, frame_done}), 64'd0);
        tick();
        run_frame(4'b1101, 12'h3F0, 4'b0110, "R8 restart");

        // R6: sticky set, survives reads
        pulse_flags(1'b1, 1'b0); exp_p = 1'b1;
        run_frame(4'h4, 12'h111, 4'h2, "R6 set");
        run_frame(4'h5, 12'h222, 4'h3, "R6 sticky");
        pulse_flags(1'b0, 1'b1); exp_p = 1'b0;
        run_frame(4'h6, 12'h333, 4'h4, "R6 clear");
        // R7: both at once
        pulse_flags(1'b1, 1'b1); exp_p = 1'b1;
        run_frame(4'h7, 12'h444, 4'h5, "R7 set wins");
        pulse_flags(1'b0, 1'b1); exp_p = 1'b0;

        // random frames with random flag events (R3, R5)
        for (int n = 0; n < 20; n++) begin
            int r;
            r = int'($urandom_range(0, 3));
            if (r == 1) begin pulse_flags(1'b1, 1'b0); exp_p = 1'b1; end
            else if (r == 2) begin pulse_flags(1'b0, 1'b1); exp_p = 1'b0; end
            else if (r == 3) begin pulse_flags(1'b1, 1'b1); exp_p = 1'b1; end
            run_frame(4'($urandom), 12'($urandom), STAT_W'($urandom), "R5 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule